// File: doc/BRIEF.md
# Byte Programming Sequencer

This block is a clocked controller that writes a whole image into an electrically programmable read-only memory, one byte at a time, using a pulse-and-verify loop. It steps an address counter from the first location to the last. For each byte it fetches the intended value from a data-source read port, drives the memory address and data pins, and raises the programming supply select. It then applies a timed low pulse on the program strobe and reads the byte back with the output enable. A byte that reads back wrong gets another pulse, up to a fixed retry limit.

After the last byte has been programmed, the controller returns the supplies to the reduced read level. It then reads every location once more and compares each against the source. All setup, hold, pulse and access windows are counted in clock cycles set by parameters.

The outcome appears on the pass and fail flags together with a done flag. On failure the offending address is held for inspection. All of this stays in place until the next start.

Top module: `byte_prog_sequencer`

## Requirements
- R1: Out of reset and while idle, the chip enable, output enable and program strobes are high, the data bus drive is off, the supply select is 0 (read level), and done, pass and fail are 0.
- R2: A start pulse while idle begins at address 0 with the pulse counter cleared and the supply select at 1 (programming level). A start while the sequence runs is ignored and does not disturb the pulse sequence.
- R3: Each program pulse holds the program strobe low for exactly PULSE_CYC cycles. During the pulse, chip enable is low, output enable is high, the data bus is driven and the supply select is 1.
- R4: Address and data are driven and unchanged for at least SETUP_CYC cycles before the program strobe falls. Data stays driven and unchanged for at least HOLD_CYC cycles after it rises.
- R5: Output enable falls only while the bus drive is off. In the programming phase it falls at least HOLD_CYC+OES_CYC cycles after the program strobe rose. Read data is compared SAMPLE_CYC cycles after output enable falls.
- R6: When the read-back byte differs from the intended byte, the same address gets another pulse with the same data. The pulse counter restarts at 0 for every new address.
- R7: When MAX_PULSES pulses at one address all fail verification, the run ends with fail=1 and fail_addr equal to that address, and no further pulse is issued.
- R8: When verification matches, the next address is programmed. After a match at the last address (all ones), the final pass begins.
- R9: The final pass sets the supply select to 0 and reads addresses from 0 upward. The first mismatch ends the run with fail=1 and fail_addr set to that address. If all bytes match, the run ends with pass=1.
- R10: Done rises together with pass or fail and, like them and fail_addr, holds until the next start. A start from this state launches a new run.
- R11: The source byte for an address is taken on the second clock edge after src_addr changes, so a source with one registered stage of latency is supported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a programming run when idle |
| src_addr | output | ADDR_W | Address presented to the data source |
| src_data | input | DATA_W | Intended byte from the data source, one cycle latency |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_dq_out | output | DATA_W | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | DATA_W | Data read from the memory |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_pgm_n | output | 1 | Program strobe, active low |
| prog_supply | output | 1 | Supply select: 1 programming levels, 0 reduced read level |
| done | output | 1 | Run finished, held until next start |
| pass | output | 1 | All bytes verified in the final pass |
| fail | output | 1 | Retry limit hit or final compare mismatch |
| fail_addr | output | ADDR_W | Address that caused the failure |

## Verification
The bench builds the block with ADDR_W=3, so the last address and the full final pass fall within a few hundred cycles. MAX_PULSES=4 lets a byte reach the retry limit, both exactly at the limit and one past it, at the first and at a middle address. The timing counts are cut to between 2 and 5 cycles, so pulse width, setup, hold and access windows are measured edge for edge. The memory model returns inverted data until output enable has been low for SAMPLE_CYC cycles. It also holds bytes that read correctly only at the programming supply level, so early sampling and final-pass failures both become visible.

// File: rtl/byte_prog_sequencer.sv
module byte_prog_sequencer #(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int SETUP_CYC  = 250,
  parameter int PULSE_CYC  = 12500,
  parameter int HOLD_CYC   = 250,
  parameter int OES_CYC    = 250,
  parameter int SAMPLE_CYC = 19,
  parameter int SETTLE_CYC = 250,
  parameter int MAX_PULSES = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [ADDR_W-1:0] src_addr,
  input  logic [DATA_W-1:0] src_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_pgm_n,
  output logic              prog_supply,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr
);

  localparam int M1     = (PULSE_CYC > SETUP_CYC) ? PULSE_CYC : SETUP_CYC;
  localparam int M2     = (HOLD_CYC > OES_CYC) ? HOLD_CYC : OES_CYC;
  localparam int M3     = (SAMPLE_CYC > SETTLE_CYC) ? SAMPLE_CYC : SETTLE_CYC;
  localparam int M12    = (M1 > M2) ? M1 : M2;
  localparam int TMAX   = (M12 > M3) ? M12 : M3;
  localparam int TMR_W  = $clog2(TMAX + 2);
  localparam int PCNT_W = $clog2(MAX_PULSES + 1);
  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

  typedef enum logic [3:0] {
    S_IDLE, S_LOAD, S_SETUP, S_PULSE, S_HOLD,
    S_TURN, S_VERIFY, S_GAP, S_SWITCH, S_FREAD
  } st_t;

  st_t               st, nx;
  logic [TMR_W-1:0]  tmr, lim;
  logic [PCNT_W-1:0] pcnt;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] tgt;
  logic              fin_q;
  logic              t_end, match, is_last, limit_hit;

  assign match     = (mem_dq_in == tgt);
  assign is_last   = (addr == LAST);
  assign limit_hit = ((pcnt + 1'b1) == PCNT_W'(MAX_PULSES));
  assign t_end     = (tmr == lim);

  always_comb begin
    case (st)
      S_LOAD:   lim = TMR_W'(1);
      S_SETUP:  lim = TMR_W'(SETUP_CYC - 1);
      S_PULSE:  lim = TMR_W'(PULSE_CYC - 1);
      S_HOLD:   lim = TMR_W'(HOLD_CYC - 1);
      S_TURN:   lim = TMR_W'(OES_CYC - 1);
      S_VERIFY: lim = TMR_W'(SAMPLE_CYC - 1);
      S_FREAD:  lim = TMR_W'(SAMPLE_CYC - 1);
      S_SWITCH: lim = TMR_W'(SETTLE_CYC - 1);
      default:  lim = '0;
    endcase
  end

  always_comb begin
    nx = st;
    case (st)
      S_IDLE:   if (start) nx = S_LOAD;
      S_LOAD:   if (t_end) nx = fin_q ? S_FREAD : S_SETUP;
      S_SETUP:  if (t_end) nx = S_PULSE;
      S_PULSE:  if (t_end) nx = S_HOLD;
      S_HOLD:   if (t_end) nx = S_TURN;
      S_TURN:   if (t_end) nx = S_VERIFY;
      S_VERIFY: if (t_end) begin
                  if (match)          nx = is_last ? S_SWITCH : S_LOAD;
                  else if (limit_hit) nx = S_IDLE;
                  else                nx = S_GAP;
                end
      S_GAP:    nx = S_SETUP;
      S_SWITCH: if (t_end) nx = S_LOAD;
      S_FREAD:  if (t_end) nx = (match && !is_last) ? S_LOAD : S_IDLE;
      default:  nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      tmr       <= '0;
      pcnt      <= '0;
      addr      <= '0;
      tgt       <= '0;
      fin_q     <= 1'b0;
      done      <= 1'b0;
      pass      <= 1'b0;
      fail      <= 1'b0;
      fail_addr <= '0;
    end else begin
      st  <= nx;
      tmr <= (nx != st || st == S_IDLE) ? '0 : tmr + 1'b1;
      case (st)
        S_IDLE: if (start) begin
          addr      <= '0;
          pcnt      <= '0;
          fin_q     <= 1'b0;
          done      <= 1'b0;
          pass      <= 1'b0;
          fail      <= 1'b0;
          fail_addr <= '0;
        end
        S_LOAD: if (t_end) tgt <= src_data;
        S_VERIFY: if (t_end) begin
          if (match) begin
            pcnt <= '0;
            if (is_last) begin
              addr  <= '0;
              fin_q <= 1'b1;
            end else begin
              addr <= addr + 1'b1;
            end
          end else begin
            pcnt <= pcnt + 1'b1;
            if (limit_hit) begin
              fail      <= 1'b1;
              done      <= 1'b1;
              fail_addr <= addr;
            end
          end
        end
        S_FREAD: if (t_end) begin
          if (!match) begin
            fail      <= 1'b1;
            done      <= 1'b1;
            fail_addr <= addr;
          end else if (is_last) begin
            pass <= 1'b1;
            done <= 1'b1;
          end else begin
            addr <= addr + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign src_addr    = addr;
  assign mem_addr    = addr;
  assign mem_dq_out  = tgt;
  assign mem_dq_oe   = (st == S_SETUP) || (st == S_PULSE) || (st == S_HOLD);
  assign mem_pgm_n   = (st != S_PULSE);
  assign mem_oe_n    = !((st == S_VERIFY) || (st == S_FREAD));
  assign mem_ce_n    = (st == S_IDLE) || (st == S_LOAD) || (st == S_SWITCH);
  assign prog_supply = (st != S_IDLE) && !fin_q;

  a_r3_pulse_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_pgm_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe && prog_supply));

  a_r4_pins_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_pgm_n && !$past(mem_pgm_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

  a_r5_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe);

  a_r7_quiet_after_fail: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (mem_pgm_n && mem_ce_n && !mem_dq_oe));

  a_r10_outcome_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (pass || fail) |-> (done && !(pass && fail)));

  a_r10_outcome_held: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(pass) && $stable(fail) && $stable(fail_addr)));

endmodule

// File: tb/sim_byte_prog_sequencer.sv
module sim_byte_prog_sequencer;
  localparam int AW = 3, DW = 8, NB = 8;
  localparam int SU = 3, PW = 5, HO = 2, OE = 2, SA = 3, ST = 4, MX = 4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] src_addr, mem_addr, fail_addr;
  logic [DW-1:0] src_data, mem_dq_out, mem_dq_in;
  logic mem_dq_oe, mem_ce_n, mem_oe_n, mem_pgm_n, prog_supply, done, pass, fail;

  always #4 clk = ~clk;

  byte_prog_sequencer #(.ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(SU), .PULSE_CYC(PW),
    .HOLD_CYC(HO), .OES_CYC(OE), .SAMPLE_CYC(SA), .SETTLE_CYC(ST), .MAX_PULSES(MX)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .src_addr(src_addr), .src_data(src_data),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_pgm_n(mem_pgm_n), .prog_supply(prog_supply),
    .done(done), .pass(pass), .fail(fail), .fail_addr(fail_addr));

  int total = 0, bad = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory and source models
  logic [DW-1:0] want [NB];
  logic [DW-1:0] img  [NB];
  int            need [NB];
  bit            marg [NB];
  logic [DW-1:0] src_q;
  int            oe_cnt = 0;
  logic [DW-1:0] rd_val;

  always @(posedge clk) src_q <= want[src_addr];
  assign src_data = src_q;
  assign rd_val   = (!prog_supply && marg[mem_addr]) ? (img[mem_addr] ^ 8'h01) : img[mem_addr];
  assign mem_dq_in = (!mem_ce_n && !mem_oe_n && oe_cnt >= SA) ? rd_val : ~rd_val;

  // scoreboard
  int qa[$], qd[$];
  int stab = 0, pwc = 0, hc = 0, since_rise = 1000, final_reads = 0;
  bit hold_trk = 1'b0;
  logic pgm_p = 1'b1, oe_p = 1'b1;
  logic [AW-1:0] a_p = '0;
  logic [DW-1:0] d_p = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      oe_cnt = mem_oe_n ? 0 : oe_cnt + 1;
      if (!(mem_dq_oe && !mem_ce_n)) stab = 0;
      else if (mem_addr != a_p || mem_dq_out != d_p) stab = 1;
      else if (mem_pgm_n) stab++;

      if (pgm_p && !mem_pgm_n) begin
        chk(prog_supply && mem_dq_oe && !mem_ce_n && mem_oe_n, "R3", "pulse frame", {prog_supply, mem_dq_oe, mem_ce_n, mem_oe_n}, 4'b1101);
        chk(stab >= SU, "R4", "setup cycles", stab, SU);
        if (qa.size() == 0) chk(1'b0, "R7", "unexpected pulse at addr", mem_addr, 0);
        else begin
          int ea, ed;
          ea = qa.pop_front();
          ed = qd.pop_front();
          chk(mem_addr == AW'(ea), "R8", "pulse address", mem_addr, ea);
          chk(mem_dq_out == DW'(ed), "R11", "pulse data", mem_dq_out, ed);
        end
        pwc = 1;
      end else if (!mem_pgm_n) pwc++;

      if (!pgm_p && mem_pgm_n) begin
        chk(pwc == PW, "R3", "pulse width", pwc, PW);
        if (need[mem_addr] > 0) begin
          need[mem_addr]--;
          if (need[mem_addr] == 0) img[mem_addr] = img[mem_addr] & mem_dq_out;
        end
        hold_trk = 1'b1;
        hc = 1;
        since_rise = 1;
      end else begin
        since_rise++;
        if (hold_trk) begin
          if (mem_dq_oe && mem_dq_out == d_p && mem_addr == a_p) hc++;
          else begin
            chk(hc >= HO, "R4", "hold cycles", hc, HO);
            hold_trk = 1'b0;
          end
        end
      end

      if (oe_p && !mem_oe_n) begin
        chk(!mem_dq_oe, "R5", "bus released at oe fall", mem_dq_oe, 0);
        if (prog_supply) chk(since_rise > HO + OE, "R5", "oe setup", since_rise, HO + OE + 1);
        else final_reads++;
      end
      pgm_p = mem_pgm_n;
      oe_p  = mem_oe_n;
      a_p   = mem_addr;
      d_p   = mem_dq_out;
    end
  end

  // driver: fills the model and pushes expected pulses
  task automatic run_case(input string name, input int nd[NB], input bit mg[NB], input int seed,
                          input bit poke);
    bit exp_fail = 1'b0;
    int exp_faddr = 0, exp_reads = 0;
    for (int a = 0; a < NB; a++) begin
      want[a] = DW'(a * 37 + seed);
      img[a]  = '1;
      need[a] = nd[a];
      marg[a] = mg[a];
    end
    for (int a = 0; a < NB; a++) begin
      int n = (nd[a] > MX) ? MX : nd[a];
      for (int k = 0; k < n; k++) begin qa.push_back(a); qd.push_back(want[a]); end
      if (nd[a] > MX) begin exp_fail = 1'b1; exp_faddr = a; break; end
    end
    if (!exp_fail) begin
      exp_reads = NB;
      for (int a = 0; a < NB; a++) if (mg[a]) begin exp_fail = 1'b1; exp_faddr = a; exp_reads = a + 1; break; end
    end
    final_reads = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(!done && !pass && !fail, "R10", {name, " flags cleared by start"}, {done, pass, fail}, 0);
    chk(mem_addr == 0 && prog_supply, "R2", {name, " begins at 0, programming level"}, {mem_addr, prog_supply}, 1);
    if (poke) begin
      repeat (40) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
    chk(done, "R10", {name, " done reached"}, done, 1);
    chk(pass == !exp_fail && fail == exp_fail, exp_fail ? "R7" : "R9", {name, " outcome"}, {pass, fail}, {!exp_fail, exp_fail});
    if (exp_fail) chk(fail_addr == AW'(exp_faddr), "R9", {name, " fail_addr"}, fail_addr, exp_faddr);
    chk(qa.size() == 0, "R6", {name, " pulses left unseen"}, qa.size(), 0);
    chk(final_reads == exp_reads, "R9", {name, " final pass reads"}, final_reads, exp_reads);
    repeat (30) @(negedge clk);
    chk(done && pass == !exp_fail && fail == exp_fail, "R10", {name, " outcome held"}, {done, pass, fail}, {1'b1, !exp_fail, exp_fail});
    chk(mem_pgm_n && mem_oe_n && mem_ce_n && !prog_supply, "R1", {name, " idle pins after run"},
        {mem_pgm_n, mem_oe_n, mem_ce_n, prog_supply}, 4'b1110);
    qa.delete();
    qd.delete();
  endtask

  initial begin
    int n1[NB], n2[NB], n3[NB], n4[NB];
    bit m0[NB], m5[NB], m6[NB];
    for (int a = 0; a < NB; a++) begin
      n1[a] = 1; n3[a] = 1; n4[a] = 1; m0[a] = 0; m5[a] = 0; m6[a] = 0;
      want[a] = '0; img[a] = '1; need[a] = 1; marg[a] = 0;
    end
    n2 = '{1, 3, 4, 2, 1, 4, 2, 1};
    n3[5] = 5;
    n4[0] = 5;
    m5[7] = 1;
    m6[2] = 1; m6[5] = 1;
    repeat (3) @(negedge clk);
    chk(mem_pgm_n && mem_oe_n && mem_ce_n && !mem_dq_oe && !prog_supply && !done && !pass && !fail,
        "R1", "reset state", {mem_pgm_n, mem_oe_n, mem_ce_n, mem_dq_oe, prog_supply, done, pass, fail}, 8'hE0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_case("single-pulse image, start poked mid-run (R2)", n1, m0, 5, 1'b1);
    run_case("mixed pulses up to limit (R6)", n2, m0, 91, 1'b0);
    run_case("limit exceeded mid image (R7)", n3, m0, 17, 1'b0);
    run_case("limit exceeded at first byte (R7)", n4, m0, 200, 1'b0);
    run_case("last byte weak at read level (R9)", n1, m5, 3, 1'b0);
    run_case("two weak bytes, first reported (R9)", n2, m6, 60, 1'b0);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      chk(1'b0, "R10", "watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule